// File: doc/BRIEF.md
# SPI Receive Word Pattern Matcher

This block sits beside the receive path of an SPI controller and inspects every received word. Two compare values and a three-bit mode select a pattern: one word at the start of a frame, any word in the frame, a two-word sequence, or a masked compare in which the second compare value acts as a bit mask. A hit sets a sticky match flag. Software clears the flag by writing a one to it, and the flag raises an interrupt when enabled.

An optional match-gated storage mode tells the receive buffer which words to keep. Words are dropped until a pattern hit occurs. The word that completes the hit and every word after it in the same frame are kept. The bit shifter, the buffer and the register interface are outside this block.

Top module: `spi_rx_match`

## Requirements
- R1: With mode 0 (off) or mode 1 (reserved) the match flag is never set.
- R2: Mode 2 sets the flag when the first word of a frame (the word presented with `rx_sof`) equals `cfg_match_a` or `cfg_match_b`.
- R3: Mode 3 sets the flag when any received word equals `cfg_match_a` or `cfg_match_b`.
- R4: Mode 4 sets the flag only when the first word of a frame equals `cfg_match_a` and the second word of that frame equals `cfg_match_b`.
- R5: Mode 5 sets the flag when two consecutive words of one frame are `cfg_match_a` then `cfg_match_b`. The sequence state is cleared at every start of frame, so a pair that spans two frames does not match.
- R6: Mode 6 sets the flag when the first word of a frame satisfies `(data & cfg_match_b) == (cfg_match_a & cfg_match_b)`.
- R7: Mode 7 applies the masked compare of R6 to every word of the frame.
- R8: `match_flag` rises on the clock edge that accepts a hitting word, and stays set until a cycle with `flag_clr` high and no new hit. A hit in the same cycle as `flag_clr` leaves the flag set.
- R9: `irq` is high exactly when `match_flag` and `irq_en` are both high.
- R10: With `cfg_match_only` low, `store_word` equals `rx_valid`.
- R11: With `cfg_match_only` high, words are dropped until a hit. The hitting word and the following words are stored until the cycle that carries `frame_end`, or until the next `rx_sof`, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received word is presented this cycle |
| rx_sof | input | 1 | The presented word is the first word of a frame |
| rx_data | input | DATA_W | Received word |
| frame_end | input | 1 | The current frame ends after this cycle |
| cfg_mode | input | 3 | Match mode 0..7 |
| cfg_match_a | input | DATA_W | First compare value |
| cfg_match_b | input | DATA_W | Second compare value, or the mask in modes 6 and 7 |
| cfg_match_only | input | 1 | Store only words from a hit onward |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Match interrupt |
| store_word | output | 1 | The presented word should be written to the receive buffer |

## Verification
The assertions assume that the mode and both compare values stay constant while a frame is in progress. They also assume that `rx_sof` is only meaningful together with `rx_valid`. The stimulus changes the configuration only between frames and raises `rx_sof` only on valid words. `frame_end` is driven on the last word of each frame or on an idle cycle. The stimulus includes a sequence split across a frame boundary, a clear that collides with a hit, and a hit that falls on the last word of a frame.

// File: rtl/spi_match_pkg.sv
// Shared encodings for the receive pattern matcher.
package spi_match_pkg;
    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_RSVD    = 3'd1,
        FIRST_EITHER = 3'd2,
        ANY_EITHER   = 3'd3,
        FIRST_PAIR   = 3'd4,
        ANY_PAIR     = 3'd5,
        FIRST_MASK   = 3'd6,
        ANY_MASK     = 3'd7
    } match_mode_e;
endpackage

// File: rtl/spi_match_cmp.sv
// Word comparators: equality to each compare value and a masked compare.
// Assumes: pure combinational; the operands are stable within the cycle.
module spi_match_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] ref_a,
    input  logic [DATA_W-1:0] ref_b,
    output logic              eq_a,
    output logic              eq_b,
    output logic              eq_mask
);
    logic [DATA_W-1:0] bit_ok;

    // Per-bit masked agreement: a bit passes if it is masked out or equal.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_ok[i] = ~ref_b[i] | (word[i] ~^ ref_a[i]);
    end

    // Reduce the comparisons.
    always_comb begin
        eq_a    = (word == ref_a);
        eq_b    = (word == ref_b);
        eq_mask = &bit_ok;
    end
endmodule

// File: rtl/spi_match_seq.sv
// Pattern selection and the two-word sequence state.
// Assumes: the mode is held constant while a frame is in progress.
module spi_match_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic [2:0] mode,
    input  logic       eq_a,
    input  logic       eq_b,
    input  logic       eq_mask,
    output logic       hit
);
    import spi_match_pkg::*;

    logic        prev_a;     // previous word of this frame equalled value A
    logic        second;     // the next word is the second word of the frame
    logic        prev_eff;
    logic        pair_any;
    logic        pair_first;
    match_mode_e sel;

    // Pattern decode for the presented word.
    always_comb begin
        sel        = match_mode_e'(mode);
        prev_eff   = prev_a & ~rx_sof;
        pair_any   = prev_eff & eq_b;
        pair_first = pair_any & second;
        unique case (sel)
            FIRST_EITHER: hit = rx_sof & (eq_a | eq_b);
            ANY_EITHER:   hit = eq_a | eq_b;
            FIRST_PAIR:   hit = pair_first;
            ANY_PAIR:     hit = pair_any;
            FIRST_MASK:   hit = rx_sof & eq_mask;
            ANY_MASK:     hit = eq_mask;
            default:      hit = 1'b0;
        endcase
        hit = hit & rx_valid;
    end

    // Track the previous-word state and the position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            second <= 1'b0;
        end else if (rx_valid) begin
            prev_a <= eq_a;
            second <= rx_sof;
        end
    end
endmodule

// File: rtl/spi_match_gate.sv
// Sticky flag with write-one-to-clear, and the match-gated storage window.
// Assumes: frame_end is a single-cycle strobe on or after the last word.
module spi_match_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_sof,
    input  logic frame_end,
    input  logic match_only,
    input  logic hit,
    input  logic flag_clr,
    output logic store_word,
    output logic match_flag
);
    logic window;   // a hit has opened storage for the rest of the frame

    // Storage decision for the presented word.
    always_comb begin
        store_word = rx_valid & (~match_only | hit | (window & ~rx_sof));
    end

    // Flag: a hit sets it, the clear strobe drops it, and a hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_flag <= 1'b0;
        else if (hit)      match_flag <= 1'b1;
        else if (flag_clr) match_flag <= 1'b0;
    end

    // Window: opened by a gated hit, closed at the frame end or a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 window <= 1'b0;
        else if (frame_end)         window <= 1'b0;
        else if (rx_valid & rx_sof) window <= match_only & hit;
        else if (match_only & hit)  window <= 1'b1;
    end
endmodule

// File: rtl/spi_rx_match.sv
// Top: receive pattern matcher with a sticky flag, interrupt and storage gate.
// Assumes: configuration stable during a frame; rx_sof only with rx_valid.
module spi_rx_match #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              frame_end,
    input  logic [2:0]        cfg_mode,
    input  logic [DATA_W-1:0] cfg_match_a,
    input  logic [DATA_W-1:0] cfg_match_b,
    input  logic              cfg_match_only,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              match_flag,
    output logic              irq,
    output logic              store_word
);
    logic eq_a, eq_b, eq_mask, hit;

    spi_match_cmp #(.DATA_W(DATA_W)) u_cmp (
        .word(rx_data), .ref_a(cfg_match_a), .ref_b(cfg_match_b),
        .eq_a(eq_a), .eq_b(eq_b), .eq_mask(eq_mask)
    );

    spi_match_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .mode(cfg_mode), .eq_a(eq_a), .eq_b(eq_b), .eq_mask(eq_mask),
        .hit(hit)
    );

    spi_match_gate u_gate (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .frame_end(frame_end), .match_only(cfg_match_only), .hit(hit),
        .flag_clr(flag_clr), .store_word(store_word), .match_flag(match_flag)
    );

    // Interrupt output.
    always_comb irq = match_flag & irq_en;
endmodule

// File: rtl/spi_rx_match_chk.sv
// Checker for spi_rx_match, attached through bind.
module spi_rx_match_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_sof,
    input logic [DATA_W-1:0] rx_data,
    input logic [2:0]        cfg_mode,
    input logic [DATA_W-1:0] cfg_match_a,
    input logic              cfg_match_only,
    input logic              irq_en,
    input logic              flag_clr,
    input logic              match_flag,
    input logic              irq,
    input logic              store_word
);
    assert_off_never_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode < 3'd2 && !match_flag) |=> !match_flag);

    assert_first_word_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && cfg_mode == 3'd2 && rx_data == cfg_match_a) |=> match_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && flag_clr && !rx_valid) |=> !match_flag);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && irq_en));

    assert_store_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_match_only |-> (store_word == rx_valid));

    assert_store_needs_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> !store_word);
endmodule

bind spi_rx_match spi_rx_match_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .cfg_mode(cfg_mode), .cfg_match_a(cfg_match_a),
    .cfg_match_only(cfg_match_only), .irq_en(irq_en), .flag_clr(flag_clr),
    .match_flag(match_flag), .irq(irq), .store_word(store_word)
);

// File: tb/spi_rx_match_test.sv
// Bench: behavioural reference model compared with the design on every clock.
module spi_rx_match_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, frame_end = 1'b0;
    logic [31:0] rx_data = '0, cfg_match_a = '0, cfg_match_b = '0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_match_only = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic        match_flag, irq, store_word;

    int tests = 0, fails = 0;
    bit finished = 0;

    // Reference state
    bit          m_flag = 0, m_window = 0, m_prev_ok = 0;
    int          m_idx = 2;
    logic [31:0] m_prev = '0;

    always #4 clk = ~clk;

    spi_rx_match uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .frame_end(frame_end), .cfg_mode(cfg_mode),
        .cfg_match_a(cfg_match_a), .cfg_match_b(cfg_match_b),
        .cfg_match_only(cfg_match_only), .irq_en(irq_en), .flag_clr(flag_clr),
        .match_flag(match_flag), .irq(irq), .store_word(store_word)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            3'd7: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic bit model_hit();
        int  idx = rx_sof ? 0 : m_idx;
        bit  pv  = m_prev_ok && !rx_sof;
        bit  ea  = (rx_data == cfg_match_a);
        bit  eb  = (rx_data == cfg_match_b);
        bit  em  = ((rx_data & cfg_match_b) == (cfg_match_a & cfg_match_b));
        if (!rx_valid) return 0;
        case (cfg_mode)
            3'd2: return idx == 0 && (ea || eb);
            3'd3: return ea || eb;
            3'd4: return idx == 1 && pv && m_prev == cfg_match_a && eb;
            3'd5: return pv && m_prev == cfg_match_a && eb;
            3'd6: return idx == 0 && em;
            3'd7: return em;
            default: return 0;
        endcase
    endfunction

    // One clock: drive, check combinational outputs, advance, check the flag.
    task automatic step(input bit v, input bit s, input logic [31:0] d,
                        input bit fe, input bit clr);
        bit h, exp_store, nxt_flag, nxt_win;
        rx_valid = v; rx_sof = s; rx_data = d; frame_end = fe; flag_clr = clr;
        #1;
        h = model_hit();
        exp_store = v && (!cfg_match_only || h || (m_window && !s));
        check(store_word == exp_store, cfg_match_only ? "R11" : "R10",
              int'(store_word), int'(exp_store));
        check(irq == (m_flag && irq_en), "R9", int'(irq), int'(m_flag && irq_en));
        nxt_flag = h ? 1'b1 : (clr ? 1'b0 : m_flag);
        if (fe)               nxt_win = 0;
        else if (v && s)      nxt_win = cfg_match_only && h;
        else                  nxt_win = m_window || (cfg_match_only && h);
        @(posedge clk);
        m_flag = nxt_flag;
        m_window = nxt_win;
        if (v) begin
            m_idx = s ? 1 : (m_idx < 2 ? m_idx + 1 : 2);
            m_prev = d;
            m_prev_ok = 1;
        end
        @(negedge clk);
        check(match_flag == m_flag, h ? mode_tag(cfg_mode) : "R8",
              int'(match_flag), int'(m_flag));
    endtask

    task automatic idle(input bit clr);
        step(0, 0, 32'h0, 0, clr);
    endtask

    task automatic clear_flag();
        step(0, 0, 32'h0, 1, 1);
    endtask

    localparam logic [31:0] VA = 32'hA5A5_0001, VB = 32'h5A5A_0002;

    initial begin
        repeat (2) @(negedge clk);
        check(match_flag == 0, "R8", int'(match_flag), 0);
        check(irq == 0, "R9", int'(irq), 0);
        rst_n = 1;
        cfg_match_a = VA; cfg_match_b = VB; irq_en = 1;

        // R1: modes 0 and 1 never flag
        for (int m = 0; m < 2; m++) begin
            cfg_mode = 3'(m);
            step(1, 1, VA, 0, 0); step(1, 0, VB, 0, 0); step(1, 0, VA, 1, 0);
            check(match_flag == 0, "R1", int'(match_flag), 0);
        end

        // R2: first word only
        cfg_mode = 3'd2;
        step(1, 1, 32'h1, 0, 0); step(1, 0, VA, 1, 0);
        check(match_flag == 0, "R2", int'(match_flag), 0);
        step(1, 1, VB, 0, 0); step(1, 0, 32'h3, 1, 0);
        check(match_flag == 1, "R2", int'(match_flag), 1);
        clear_flag();
        step(1, 1, VA, 1, 0);
        clear_flag();

        // R3: any word
        cfg_mode = 3'd3;
        step(1, 1, 32'h7, 0, 0); step(1, 0, 32'h8, 0, 0); step(1, 0, VB, 1, 0);
        check(match_flag == 1, "R3", int'(match_flag), 1);
        // R8: hit collides with clear, set wins
        step(1, 1, VA, 0, 1);
        check(match_flag == 1, "R8", int'(match_flag), 1);
        irq_en = 0; idle(0); irq_en = 1;
        step(0, 0, 32'h0, 1, 1);
        check(match_flag == 0, "R8", int'(match_flag), 0);

        // R4: first pair only
        cfg_mode = 3'd4;
        step(1, 1, 32'h9, 0, 0); step(1, 0, VA, 0, 0); step(1, 0, VB, 1, 0);
        check(match_flag == 0, "R4", int'(match_flag), 0);
        step(1, 1, VA, 0, 0); step(1, 0, VB, 1, 0);
        check(match_flag == 1, "R4", int'(match_flag), 1);
        clear_flag();

        // R5: pair anywhere, but not across frames
        cfg_mode = 3'd5;
        step(1, 1, 32'h9, 0, 0); step(1, 0, VA, 1, 0);
        step(1, 1, VB, 0, 0); step(1, 0, 32'h4, 1, 0);
        check(match_flag == 0, "R5", int'(match_flag), 0);
        step(1, 1, 32'h9, 0, 0); step(1, 0, 32'h9, 0, 0);
        step(1, 0, VA, 0, 0); step(1, 0, VB, 1, 0);
        check(match_flag == 1, "R5", int'(match_flag), 1);
        clear_flag();

        // R6 / R7: masked compare, B is the mask
        cfg_match_a = 32'h1200_3400; cfg_match_b = 32'hFF00_FF00;
        cfg_mode = 3'd6;
        step(1, 1, 32'h0012_3456, 0, 0); step(1, 0, 32'h12AB_34CD, 1, 0);
        check(match_flag == 0, "R6", int'(match_flag), 0);
        step(1, 1, 32'h12AB_34CD, 1, 0);
        check(match_flag == 1, "R6", int'(match_flag), 1);
        clear_flag();
        cfg_mode = 3'd7;
        step(1, 1, 32'h1300_3400, 0, 0); step(1, 0, 32'h12FF_34FF, 1, 0);
        check(match_flag == 1, "R7", int'(match_flag), 1);
        clear_flag();

        // R11: match-gated storage
        cfg_match_a = VA; cfg_match_b = VB; cfg_mode = 3'd3; cfg_match_only = 1;
        step(1, 1, 32'h1, 0, 0);
        check(store_word == 0, "R11", int'(store_word), 0);
        step(1, 0, 32'h2, 0, 0); step(1, 0, VA, 0, 0); step(1, 0, 32'h3, 0, 0);
        step(1, 0, 32'h4, 1, 0);
        step(1, 1, 32'h5, 0, 0); step(1, 0, 32'h6, 1, 0);
        clear_flag();
        // hit on the last word, then no carry into the next frame
        step(1, 1, 32'h1, 0, 0); step(1, 0, VB, 1, 0);
        step(1, 1, 32'h2, 0, 0); step(1, 0, 32'h3, 1, 0);
        // window closed by a new frame without frame_end
        step(1, 1, VA, 0, 0); step(1, 0, 32'h7, 0, 0);
        step(1, 1, 32'h8, 0, 0); step(1, 0, 32'h9, 1, 0);
        // pair mode: only the completing word and later are kept
        cfg_mode = 3'd5;
        step(1, 1, VA, 0, 0); step(1, 0, VB, 0, 0); step(1, 0, 32'h1, 1, 0);
        cfg_match_only = 0;
        step(1, 1, 32'h1, 0, 0); step(1, 0, 32'h2, 1, 0);
        idle(1); idle(0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule